// File: doc/BRIEF.md
# Two-Bit Branch Direction Predictor with Target Cache

This unit sits beside the instruction fetch stage and tells fetch where to go next. Each fetch address is looked up in two structures at the same time. A table of two-bit saturating counters gives the direction guess. A direct-mapped target cache, tagged by the upper address bits, holds the destination of branches that were taken before. When the cache hits and the counter says taken, the next fetch address is the cached target in the same cycle. In every other case it is the sequential address, fetch PC plus 4. The lookup path is purely combinational.

When a branch, or any other instruction, leaves the pipeline, the resolution port reports its address, whether it is a branch, its outcome, its destination, and the next address that fetch chose for it. The unit trains the counter and the target cache from these values. In the same cycle it computes the correct next address and raises a mispredict flag when that address differs from the one fetch chose, so the pipeline can flush. Counters move one step per resolved branch. A guess therefore reverses only after two consecutive wrong outcomes.

Top module: `branch_predict_unit`

## Requirements
- R1: After a synchronous active-high reset, every counter holds 1 (weakly not taken) and the target cache is empty. Every lookup then reports not taken, no hit, and a next address of PC+4.
- R2: The counter used for an address is selected by PC bits [12:2] (2048 counters). Two addresses that differ only above bit 12 share one counter.
- R3: A resolved taken branch moves its counter up by one and saturates at 3. A resolved not-taken branch moves it down by one and saturates at 0.
- R4: The direction output is taken exactly when the selected counter is 2 or 3.
- R5: From a counter of 3, one not-taken resolution still leaves the prediction taken. A second one turns it to not taken.
- R6: A resolved taken branch writes the target cache entry at index PC bits [7:2], setting it valid with tag PC bits [31:8] and the resolved target. This overwrites any previous occupant.
- R7: The next address equals the cached target only when the lookup hits and the direction is taken. Otherwise it is PC+4, including a hit with a not-taken counter and a taken counter with a miss.
- R8: A lookup whose index matches a valid entry but whose tag differs is a miss.
- R9: A resolved not-taken branch leaves the target cache unchanged.
- R10: A resolution flagged as not a branch leaves all counters unchanged, whatever its outcome bit. It invalidates the target cache entry at its index only when that entry is valid and its tag matches.
- R11: The redirect address is the resolved target for a taken branch and PC+4 otherwise. The mispredict flag is high exactly when a resolution is valid and this address differs from the next address fetch chose.
- R12: When a lookup and a resolution address the same entries in one cycle, the lookup returns the state from before the update. The update is visible from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_pc | input | 32 | Fetch address to predict |
| lk_taken | output | 1 | Direction guess for lk_pc |
| lk_hit | output | 1 | Target cache hit for lk_pc |
| lk_next_pc | output | 32 | Predicted next fetch address |
| up_valid | input | 1 | A resolution is presented this cycle |
| up_is_branch | input | 1 | Resolved instruction is a conditional branch |
| up_pc | input | 32 | Address of the resolved instruction |
| up_taken | input | 1 | Resolved outcome |
| up_target | input | 32 | Resolved branch destination |
| up_pred_next | input | 32 | Next address fetch chose for this instruction |
| up_mispredict | output | 1 | Chosen next address was wrong |
| up_redirect_pc | output | 32 | Correct next address |

## Verification
The bench aims at the saturation edges of the counter. A counter that wrapped instead of saturating would flip from strongly not taken to taken after one more not-taken branch. It also steps through the two-mispredict hysteresis, where a one-bit design would flip after the first miss. Aliasing is covered: a shared counter with a foreign tag must not redirect, and an eviction must make the old branch miss. Non-branch resolutions must neither train counters nor leave a stale entry behind. A same-cycle lookup and update of one entry must still return the old state, and a design that forwarded the write would show the hit one cycle early. A behavioural model is then compared against every output on every cycle under random traffic.

// File: rtl/bp_pkg.sv
package bp_pkg;

    // Two-bit hysteresis counter states
    typedef enum logic [1:0] {
        CTR_STRONG_NT = 2'd0,
        CTR_WEAK_NT   = 2'd1,
        CTR_WEAK_T    = 2'd2,
        CTR_STRONG_T  = 2'd3
    } ctr_t;

    // Bits below the instruction word boundary, not used for indexing
    localparam int unsigned ALIGN_BITS = 2;
    localparam int unsigned INSN_BYTES = 4;

    // Saturating step toward the resolved outcome
    function automatic ctr_t ctr_step(input ctr_t cur, input logic taken);
        ctr_t nxt;
        nxt = cur;
        if (taken) begin
            if (cur != CTR_STRONG_T) nxt = ctr_t'(cur + 2'd1);
        end else begin
            if (cur != CTR_STRONG_NT) nxt = ctr_t'(cur - 2'd1);
        end
        return nxt;
    endfunction

    // Upper half of the state space predicts taken
    function automatic logic ctr_says_taken(input ctr_t cur);
        return cur[1];
    endfunction

endpackage

// File: rtl/bp_bht.sv
module bp_bht
    import bp_pkg::*;
#(
    parameter int unsigned PC_W  = 32,
    parameter int unsigned IDX_W = 11
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PC_W-1:0] rd_pc,
    output logic            rd_taken,
    input  logic            wr_en,
    input  logic [PC_W-1:0] wr_pc,
    input  logic            wr_taken
);

    localparam int unsigned DEPTH = 1 << IDX_W;

    ctr_t             tbl_q [DEPTH];
    logic [IDX_W-1:0] rd_idx;
    logic [IDX_W-1:0] wr_idx;

    assign rd_idx   = rd_pc[ALIGN_BITS +: IDX_W];
    assign wr_idx   = wr_pc[ALIGN_BITS +: IDX_W];
    assign rd_taken = ctr_says_taken(tbl_q[rd_idx]);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                tbl_q[i] <= CTR_WEAK_NT;
            end
        end else if (wr_en) begin
            tbl_q[wr_idx] <= ctr_step(tbl_q[wr_idx], wr_taken);
        end
    end

    AST_CTR_SAT_HIGH: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_taken && tbl_q[wr_idx] == CTR_STRONG_T)
        |=> tbl_q[$past(wr_idx)] == CTR_STRONG_T); // R3

    AST_CTR_SAT_LOW: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_taken && tbl_q[wr_idx] == CTR_STRONG_NT)
        |=> tbl_q[$past(wr_idx)] == CTR_STRONG_NT); // R3

    AST_CTR_RISES: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_taken && tbl_q[wr_idx] != CTR_STRONG_T)
        |=> tbl_q[$past(wr_idx)] == ctr_t'($past(tbl_q[wr_idx]) + 2'd1)); // R3

endmodule

// File: rtl/bp_btb.sv
module bp_btb
    import bp_pkg::*;
#(
    parameter int unsigned PC_W  = 32,
    parameter int unsigned IDX_W = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PC_W-1:0] rd_pc,
    output logic            rd_hit,
    output logic [PC_W-1:0] rd_target,
    input  logic            fill_en,
    input  logic [PC_W-1:0] fill_pc,
    input  logic [PC_W-1:0] fill_target,
    input  logic            kill_en,
    input  logic [PC_W-1:0] kill_pc
);

    localparam int unsigned DEPTH = 1 << IDX_W;
    localparam int unsigned TAG_LO = ALIGN_BITS + IDX_W;
    localparam int unsigned TAG_W = PC_W - TAG_LO;

    typedef struct packed {
        logic             valid;
        logic [TAG_W-1:0] tag;
        logic [PC_W-1:0]  target;
    } btb_ent_t;

    btb_ent_t         ent_all [DEPTH];
    logic [IDX_W-1:0] rd_idx, fill_idx, kill_idx;
    logic [TAG_W-1:0] rd_tag, fill_tag, kill_tag;
    btb_ent_t         rd_ent;

    assign rd_idx   = rd_pc[ALIGN_BITS +: IDX_W];
    assign fill_idx = fill_pc[ALIGN_BITS +: IDX_W];
    assign kill_idx = kill_pc[ALIGN_BITS +: IDX_W];
    assign rd_tag   = rd_pc[PC_W-1:TAG_LO];
    assign fill_tag = fill_pc[PC_W-1:TAG_LO];
    assign kill_tag = kill_pc[PC_W-1:TAG_LO];

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : gen_ent
            btb_ent_t ent_q;
            logic     fill_me, kill_me;

            assign fill_me = fill_en && (fill_idx == IDX_W'(g));
            assign kill_me = kill_en && (kill_idx == IDX_W'(g))
                             && ent_q.valid && (ent_q.tag == kill_tag);

            always_ff @(posedge clk) begin
                if (rst) begin
                    ent_q <= '0;
                end else if (fill_me) begin
                    ent_q <= '{valid: 1'b1, tag: fill_tag, target: fill_target};
                end else if (kill_me) begin
                    ent_q.valid <= 1'b0;
                end
            end

            assign ent_all[g] = ent_q;
        end
    endgenerate

    assign rd_ent    = ent_all[rd_idx];
    assign rd_hit    = rd_ent.valid && (rd_ent.tag == rd_tag);
    assign rd_target = rd_ent.target;

    AST_FILL_LANDS: assert property (@(posedge clk) disable iff (rst)
        fill_en |=> ent_all[$past(fill_idx)].valid
                 && ent_all[$past(fill_idx)].tag == $past(fill_tag)
                 && ent_all[$past(fill_idx)].target == $past(fill_target)); // R6

    AST_KILL_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (kill_en && !fill_en && ent_all[kill_idx].tag == kill_tag)
        |=> !ent_all[$past(kill_idx)].valid); // R10

endmodule

// File: rtl/branch_predict_unit.sv
module branch_predict_unit
    import bp_pkg::*;
#(
    parameter int unsigned PC_W      = 32,
    parameter int unsigned BHT_IDX_W = 11,
    parameter int unsigned BTB_IDX_W = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PC_W-1:0] lk_pc,
    output logic            lk_taken,
    output logic            lk_hit,
    output logic [PC_W-1:0] lk_next_pc,
    input  logic            up_valid,
    input  logic            up_is_branch,
    input  logic [PC_W-1:0] up_pc,
    input  logic            up_taken,
    input  logic [PC_W-1:0] up_target,
    input  logic [PC_W-1:0] up_pred_next,
    output logic            up_mispredict,
    output logic [PC_W-1:0] up_redirect_pc
);

    localparam logic [PC_W-1:0] STEP = PC_W'(INSN_BYTES);

    logic            dir_taken;
    logic            tgt_hit;
    logic [PC_W-1:0] tgt_addr;
    logic            train_en;
    logic            fill_en;
    logic            kill_en;

    assign train_en = up_valid && up_is_branch;
    assign fill_en  = train_en && up_taken;
    assign kill_en  = up_valid && !up_is_branch;

    bp_bht #(
        .PC_W  (PC_W),
        .IDX_W (BHT_IDX_W)
    ) u_bht (
        .clk      (clk),
        .rst      (rst),
        .rd_pc    (lk_pc),
        .rd_taken (dir_taken),
        .wr_en    (train_en),
        .wr_pc    (up_pc),
        .wr_taken (up_taken)
    );

    bp_btb #(
        .PC_W  (PC_W),
        .IDX_W (BTB_IDX_W)
    ) u_btb (
        .clk         (clk),
        .rst         (rst),
        .rd_pc       (lk_pc),
        .rd_hit      (tgt_hit),
        .rd_target   (tgt_addr),
        .fill_en     (fill_en),
        .fill_pc     (up_pc),
        .fill_target (up_target),
        .kill_en     (kill_en),
        .kill_pc     (up_pc)
    );

    // Fetch-side choice
    assign lk_taken   = dir_taken;
    assign lk_hit     = tgt_hit;
    assign lk_next_pc = (tgt_hit && dir_taken) ? tgt_addr : lk_pc + STEP;

    // Resolution-side check
    assign up_redirect_pc = (up_is_branch && up_taken) ? up_target : up_pc + STEP;
    assign up_mispredict  = up_valid && (up_redirect_pc != up_pred_next);

    AST_EMPTY_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !lk_hit); // R1

    AST_REDIRECT_NEEDS_HIT: assert property (@(posedge clk) disable iff (rst)
        (lk_next_pc != lk_pc + STEP) |-> (lk_hit && lk_taken)); // R7

    AST_MISP_MEANS_DIFF: assert property (@(posedge clk) disable iff (rst)
        up_mispredict |-> (up_valid && up_redirect_pc != up_pred_next)); // R11

endmodule

// File: tb/branch_predict_unit_tb.sv
module branch_predict_unit_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] lk_pc = '0;
    logic        lk_taken, lk_hit;
    logic [31:0] lk_next_pc;
    logic        up_valid = 1'b0, up_is_branch = 1'b0, up_taken = 1'b0;
    logic [31:0] up_pc = '0, up_target = '0, up_pred_next = '0;
    logic        up_mispredict;
    logic [31:0] up_redirect_pc;

    int nchk  = 0;
    int nfail = 0;

    // Behavioural reference state
    int          m_ctr [2048];
    bit          m_val [64];
    logic [23:0] m_tag [64];
    logic [31:0] m_tgt [64];

    always #5 clk = ~clk;

    branch_predict_unit u_dut (
        .clk            (clk),
        .rst            (rst),
        .lk_pc          (lk_pc),
        .lk_taken       (lk_taken),
        .lk_hit         (lk_hit),
        .lk_next_pc     (lk_next_pc),
        .up_valid       (up_valid),
        .up_is_branch   (up_is_branch),
        .up_pc          (up_pc),
        .up_taken       (up_taken),
        .up_target      (up_target),
        .up_pred_next   (up_pred_next),
        .up_mispredict  (up_mispredict),
        .up_redirect_pc (up_redirect_pc)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        nchk++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    // One cycle: drive, compare against the model, then advance the model
    task automatic step(input logic [31:0] pc, input bit uv, input bit br,
                        input bit tk, input logic [31:0] upc,
                        input logic [31:0] tgt, input logic [31:0] pn);
        int bi, ti;
        bit e_tk, e_hit, e_mis;
        logic [31:0] e_next, e_red;
        @(negedge clk);
        lk_pc = pc; up_valid = uv; up_is_branch = br; up_taken = tk;
        up_pc = upc; up_target = tgt; up_pred_next = pn;
        #1;
        bi     = int'((pc >> 2) & 32'h7FF);
        ti     = int'((pc >> 2) & 32'h3F);
        e_tk   = (m_ctr[bi] >= 2);
        e_hit  = m_val[ti] && (m_tag[ti] == pc[31:8]);
        e_next = (e_hit && e_tk) ? m_tgt[ti] : pc + 32'd4;
        e_red  = (br && tk) ? tgt : upc + 32'd4;
        e_mis  = uv && (e_red != pn);
        chk("R4", "lk_taken", 32'(lk_taken), 32'(e_tk));
        chk("R6", "lk_hit", 32'(lk_hit), 32'(e_hit));
        chk("R7", "lk_next_pc", lk_next_pc, e_next);
        chk("R11", "up_mispredict", 32'(up_mispredict), 32'(e_mis));
        chk("R11", "up_redirect_pc", up_redirect_pc, e_red);
        if (uv) begin
            bi = int'((upc >> 2) & 32'h7FF);
            ti = int'((upc >> 2) & 32'h3F);
            if (br) begin
                if (tk && m_ctr[bi] < 3) m_ctr[bi]++;
                if (!tk && m_ctr[bi] > 0) m_ctr[bi]--;
                if (tk) begin
                    m_val[ti] = 1'b1; m_tag[ti] = upc[31:8]; m_tgt[ti] = tgt;
                end
            end else if (m_val[ti] && m_tag[ti] == upc[31:8]) begin
                m_val[ti] = 1'b0;
            end
        end
    endtask

    task automatic look(input logic [31:0] pc);
        step(pc, 0, 0, 0, 32'h0, 32'h0, 32'h0);
    endtask

    task automatic train(input logic [31:0] upc, input bit br, input bit tk,
                         input logic [31:0] tgt, input logic [31:0] pn);
        step(32'h0000_0F00, 1, br, tk, upc, tgt, pn);
    endtask

    localparam logic [31:0] PA = 32'h0000_0040;
    localparam logic [31:0] PB = 32'h0000_2040;
    localparam logic [31:0] TA = 32'h0000_1000;
    localparam logic [31:0] TB = 32'h0000_3000;

    initial begin
        #2_000_000;
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 2048; i++) m_ctr[i] = 1;
        for (int i = 0; i < 64; i++) begin
            m_val[i] = 1'b0; m_tag[i] = '0; m_tgt[i] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        look(PA);
        chk("R1", "taken after reset", 32'(lk_taken), 32'd0);
        chk("R1", "hit after reset", 32'(lk_hit), 32'd0);
        chk("R1", "next after reset", lk_next_pc, PA + 4);

        // R12 and R11: lookup and update on the same entry in one cycle
        step(PA, 1, 1, 1, PA, TA, PA + 4);
        chk("R12", "same-cycle lookup sees old entry", 32'(lk_hit), 32'd0);
        chk("R11", "taken branch chosen sequential", 32'(up_mispredict), 32'd1);
        look(PA);
        chk("R12", "update visible next cycle", lk_next_pc, TA);
        chk("R6", "fill makes hit", 32'(lk_hit), 32'd1);

        // R3 up to saturation, R5 hysteresis
        train(PA, 1, 1, TA, TA);
        chk("R11", "correct taken guess", 32'(up_mispredict), 32'd0);
        train(PA, 1, 1, TA, TA);
        train(PA, 1, 0, TA, TA);
        chk("R11", "not-taken after taken guess", up_redirect_pc, PA + 4);
        look(PA);
        chk("R5", "one miss keeps taken", 32'(lk_taken), 32'd1);
        train(PA, 1, 0, TA, TA);
        look(PA);
        chk("R5", "second miss flips", 32'(lk_taken), 32'd0);
        chk("R9", "entry kept after not-taken", 32'(lk_hit), 32'd1);
        chk("R7", "hit but not taken goes sequential", lk_next_pc, PA + 4);

        // R3 low saturation
        train(PA, 1, 0, TA, PA + 4);
        train(PA, 1, 0, TA, PA + 4);
        train(PA, 1, 1, TA, PA + 4);
        look(PA);
        chk("R3", "low saturation", 32'(lk_taken), 32'd0);
        train(PA, 1, 1, TA, PA + 4);
        look(PA);
        chk("R3", "climb back to taken", lk_next_pc, TA);

        // R2 shared counter, R8 tag mismatch
        look(PB);
        chk("R2", "aliased counter shared", 32'(lk_taken), 32'd1);
        chk("R8", "foreign tag misses", 32'(lk_hit), 32'd0);
        chk("R7", "taken but miss goes sequential", lk_next_pc, PB + 4);
        train(PB, 1, 1, TB, PB + 4);
        look(PA);
        chk("R8", "evicted branch misses", 32'(lk_hit), 32'd0);
        look(PB);
        chk("R6", "new occupant target", lk_next_pc, TB);

        // R10: non-branch resolutions
        train(PB, 0, 1, 32'h0, PB + 4);
        chk("R11", "non-branch sequential ok", 32'(up_mispredict), 32'd0);
        look(PB);
        chk("R10", "matching non-branch invalidates", 32'(lk_hit), 32'd0);
        train(PA, 0, 0, 32'h0, PA + 4);
        train(PA, 0, 0, 32'h0, PA + 4);
        look(PA);
        chk("R10", "counter untouched by non-branch", 32'(lk_taken), 32'd1);
        train(PA, 0, 0, 32'h0, TA);
        chk("R11", "non-branch wrongly redirected", 32'(up_mispredict), 32'd1);

        // Random traffic against the model
        for (int n = 0; n < 600; n++) begin
            logic [31:0] pool [4];
            logic [31:0] a, u, t, p;
            int pick;
            pool[0] = PA; pool[1] = PB; pool[2] = 32'h0000_0080; pool[3] = 32'h0001_1080;
            pick = int'($urandom_range(0, 4));
            a = (pick < 4) ? pool[pick] : ($urandom() & 32'hFFFF_FFFC);
            pick = int'($urandom_range(0, 4));
            u = (pick < 4) ? pool[pick] : ($urandom() & 32'hFFFF_FFFC);
            t = 32'h0000_4000 + (($urandom() & 32'hF) << 2);
            p = $urandom_range(0, 1) ? t : u + 4;
            step(a, ($urandom_range(0, 3) != 0), ($urandom_range(0, 4) != 0),
                 $urandom_range(0, 1) == 1, u, t, p);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule